// File: doc/BRIEF.md
# Line Quality Monitor

This block gives a coarse measure of how healthy a received line is. It counts the coding-violation pulses that an upstream line decoder raises. Counting runs over a fixed measurement window, and the window's tick count depends on the line rate. The higher-rate profile (34.368 Mbit/s) uses a 10 s window. The lower-rate profile (8.448 Mbit/s) uses a 40 s window. Each window is sized so that the comparison threshold equals an error ratio of roughly one in a million.

At the end of each window the block compares the count with that profile's threshold. It then sets a single flag, which stays at that value for the whole of the next window. The count is always cleared when a window closes. A dedicated timing clock drives all the logic, so the flag means something only while that clock runs. When the receive path is in rail (codec bypass) mode, violation pulses carry no meaning and are not counted.

Window lengths in ticks and the two thresholds are parameters. A testbench can therefore use a short window.

Top module: `lqm_quality_mon`

## Requirements
- R1: While `rst_n` is low, `line_bad` is low, and it goes low at once when `rst_n` falls, without waiting for a clock edge.
- R2: The release of `rst_n` is taken in on two `tick_clk` rising edges. The first window starts at the third rising edge after the release.
- R3: A window lasts `LEN_HI` ticks when `rate_sel` is 1 and `LEN_LO` ticks when `rate_sel` is 0.
- R4: At the close of a window, `line_bad` goes high if the number of violations counted in that window is strictly greater than the threshold of the selected profile.
- R5: At the close of a window, `line_bad` goes low if the count is less than or equal to the threshold. A count equal to the threshold gives low.
- R6: `line_bad` changes only on the tick that closes a window. Between closes it holds its value.
- R7: The violation count saturates at the threshold plus one and returns to zero at every window close, so violations never carry from one window into the next.
- R8: While `rail_mode` is 1, pulses on `viol` are not counted.
- R9: A violation on the last tick of a window counts toward the window that this tick closes.
- R10: `rate_sel` = 1 selects the 34 Mbit/s profile (`LEN_HI`, `THR_HI`), and `rate_sel` = 0 selects the 8 Mbit/s profile (`LEN_LO`, `THR_LO`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_clk | input | 1 | Dedicated timing clock; one rising edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol | input | 1 | Coding-violation pulse, one violation per tick it is high |
| rate_sel | input | 1 | Profile select: 1 = 34 Mbit/s, 0 = 8 Mbit/s |
| rail_mode | input | 1 | 1 while the receive path bypasses the line decoder |
| line_bad | output | 1 | 1 if the last closed window exceeded its threshold |

## Verification
The windows are driven with violation counts of zero, exactly the threshold, and the threshold plus one. These separate a `>` comparison from a `>=` comparison, and show which profile's threshold is in use. A window with a violation on every tick separates correct saturation and clearing from counts that leak into the next window. Violations placed only after the higher-rate length show whether the lower-rate window really runs longer, and a single pulse on the closing tick shows whether the boundary is inclusive. Rail-mode windows full of violations, a check of the flag halfway through a window, and a reset asserted mid-window show the suppression, the hold behaviour and the asynchronous clear.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
  typedef enum logic {
    PROF_8M  = 1'b0,
    PROF_34M = 1'b1
  } lqm_prof_e;
endpackage

// File: rtl/lqm_rst_sync.sv
module lqm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/lqm_ivl_timer.sv
module lqm_ivl_timer
  import lqm_pkg::*;
#(
  parameter int LEN_HI = 10_000_000,
  parameter int LEN_LO = 40_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  lqm_prof_e prof,
  output logic      ivl_end
);
  localparam int LEN_MAX = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int TW      = (LEN_MAX > 2) ? $clog2(LEN_MAX) : 1;
  localparam logic [TW-1:0] LAST_HI = TW'(LEN_HI - 1);
  localparam logic [TW-1:0] LAST_LO = TW'(LEN_LO - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [TW-1:0] last_sel;
  logic          tmr_en;

  // Running timer; the compare is >= so a profile change mid-window closes it cleanly
  always_comb begin
    last_sel = (prof == PROF_34M) ? LAST_HI : LAST_LO;
    ivl_end  = (tmr_q >= last_sel);
    tmr_en   = 1'b1;
    tmr_d    = ivl_end ? '0 : tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end
endmodule

// File: rtl/lqm_viol_ctr.sv
module lqm_viol_ctr
  import lqm_pkg::*;
#(
  parameter int THR_HI = 344,
  parameter int THR_LO = 338
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      viol_en,
  input  logic      ivl_end,
  input  lqm_prof_e prof,
  output logic      over_thr,
  output logic [$clog2(((THR_HI > THR_LO) ? THR_HI : THR_LO) + 2)-1:0] cnt_o
);
  localparam int THR_MAX = (THR_HI > THR_LO) ? THR_HI : THR_LO;
  localparam int CW      = $clog2(THR_MAX + 2);
  localparam logic [CW-1:0] THRV_HI = CW'(THR_HI);
  localparam logic [CW-1:0] THRV_LO = CW'(THR_LO);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, thr_sel, sat_lim;

  always_comb begin
    thr_sel  = (prof == PROF_34M) ? THRV_HI : THRV_LO;
    sat_lim  = thr_sel + 1'b1;
    cnt_inc  = (viol_en && (cnt_q < sat_lim)) ? cnt_q + 1'b1 : cnt_q;
    over_thr = (cnt_inc > thr_sel);
    cnt_d    = ivl_end ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lqm_quality_mon.sv
module lqm_quality_mon
  import lqm_pkg::*;
#(
  parameter int LEN_HI = 10_000_000,
  parameter int LEN_LO = 40_000_000,
  parameter int THR_HI = 344,
  parameter int THR_LO = 338
) (
  input  logic tick_clk,
  input  logic rst_n,
  input  logic viol,
  input  logic rate_sel,
  input  logic rail_mode,
  output logic line_bad
);
  localparam int THR_MAX = (THR_HI > THR_LO) ? THR_HI : THR_LO;
  localparam int CW      = $clog2(THR_MAX + 2);

  logic          core_rst_n;
  logic          ivl_end;
  logic          over_thr;
  logic          viol_en;
  logic          flag_d;
  logic [CW-1:0] viol_cnt;
  lqm_prof_e     prof;

  assign prof    = rate_sel ? PROF_34M : PROF_8M;
  assign viol_en = viol & ~rail_mode;

  lqm_rst_sync u_rst (
    .clk        (tick_clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  lqm_ivl_timer #(.LEN_HI(LEN_HI), .LEN_LO(LEN_LO)) u_tmr (
    .clk     (tick_clk),
    .rst_n   (core_rst_n),
    .prof    (prof),
    .ivl_end (ivl_end)
  );

  lqm_viol_ctr #(.THR_HI(THR_HI), .THR_LO(THR_LO)) u_ctr (
    .clk      (tick_clk),
    .rst_n    (core_rst_n),
    .viol_en  (viol_en),
    .ivl_end  (ivl_end),
    .prof     (prof),
    .over_thr (over_thr),
    .cnt_o    (viol_cnt)
  );

  always_comb flag_d = ivl_end ? over_thr : line_bad;

  always_ff @(posedge tick_clk or negedge core_rst_n) begin
    if (!core_rst_n) line_bad <= 1'b0;
    else             line_bad <= flag_d;
  end
endmodule

// File: rtl/lqm_quality_mon_chk.sv
module lqm_quality_mon_chk #(
  parameter int THR_HI = 344,
  parameter int THR_LO = 338,
  parameter int CW     = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_rst_n,
  input logic          rail_mode,
  input logic          rate_sel,
  input logic          ivl_end,
  input logic [CW-1:0] viol_cnt,
  input logic          line_bad
);
  // R1: flag is low on any edge while the core is held in reset
  a_r1_reset_low: assert property (@(posedge clk) !core_rst_n |-> !line_bad);

  // R2: core reset follows the external reset, never released early
  a_r2_sync_release: assert property (@(posedge clk) !rst_n |-> !core_rst_n);

  // R6: flag only moves after a window close
  a_r6_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    !ivl_end |=> $stable(line_bad));

  // R7: counter bounded by threshold plus one
  a_r7_saturate: assert property (@(posedge clk) disable iff (!core_rst_n)
    viol_cnt <= CW'((rate_sel ? THR_HI : THR_LO) + 1) || !$stable(rate_sel));

  // R7: counter empty after a close
  a_r7_clear: assert property (@(posedge clk) disable iff (!core_rst_n)
    ivl_end |=> viol_cnt == '0);

  // R8: in rail mode the counter never grows
  a_r8_rail_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    rail_mode |=> viol_cnt <= $past(viol_cnt));
endmodule

bind lqm_quality_mon lqm_quality_mon_chk #(
  .THR_HI(THR_HI), .THR_LO(THR_LO), .CW(CW)
) u_chk (
  .clk        (tick_clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .rail_mode  (rail_mode),
  .rate_sel   (rate_sel),
  .ivl_end    (ivl_end),
  .viol_cnt   (viol_cnt),
  .line_bad   (line_bad)
);

// File: tb/lqm_quality_mon_test.sv
`timescale 1ns/1ps
module lqm_quality_mon_test;
  localparam int LHI = 12;
  localparam int LLO = 20;
  localparam int THI = 3;
  localparam int TLO = 5;

  logic clk = 1'b0;
  logic rst_n, viol, rate_sel, rail_mode;
  logic line_bad;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  always #2 clk = ~clk;

  lqm_quality_mon #(.LEN_HI(LHI), .LEN_LO(LLO), .THR_HI(THI), .THR_LO(TLO)) uut (
    .tick_clk  (clk),
    .rst_n     (rst_n),
    .viol      (viol),
    .rate_sel  (rate_sel),
    .rail_mode (rail_mode),
    .line_bad  (line_bad)
  );

  // vector: {rate, rail, n_viol[4:0], expected}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd0,  1'b0},
    {1'b1, 1'b0, 5'd3,  1'b0},
    {1'b1, 1'b0, 5'd4,  1'b1},
    {1'b0, 1'b0, 5'd5,  1'b0},
    {1'b0, 1'b0, 5'd6,  1'b1},
    {1'b1, 1'b0, 5'd12, 1'b1},
    {1'b1, 1'b0, 5'd0,  1'b0},
    {1'b0, 1'b0, 5'd20, 1'b1},
    {1'b1, 1'b1, 5'd12, 1'b0},
    {1'b0, 1'b1, 5'd20, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: line_bad=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic r, input logic rl, input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      rate_sel  = r;
      rail_mode = rl;
      viol      = v;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; viol = 1'b0; rate_sel = 1'b1; rail_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", line_bad, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);  // R2 two-edge release

    // R4 R5 R7 R8 R10: table walk, one window per row
    for (int k = 0; k < NV; k++) begin
      int len;
      int n;
      len = VEC[k][7] ? LHI : LLO;
      n   = int'(VEC[k][5:1]);
      drive(VEC[k][7], VEC[k][6], 1'b1, n);
      drive(VEC[k][7], VEC[k][6], 1'b0, len - n);
      check($sformatf("R4/R5/R7/R8/R10 row %0d", k), line_bad, VEC[k][0]);
    end

    // R9: closing-tick violation counts (3 early + 1 on last tick of 12)
    drive(1'b1, 1'b0, 1'b1, 3);
    drive(1'b1, 1'b0, 1'b0, LHI - 4);
    drive(1'b1, 1'b0, 1'b1, 1);
    check("R9 last tick counts", line_bad, 1'b1);

    // R6: flag holds mid-window, then clears at close
    drive(1'b1, 1'b0, 1'b0, LHI / 2);
    check("R6 hold mid window", line_bad, 1'b1);
    drive(1'b1, 1'b0, 1'b0, LHI - LHI / 2);
    check("R5 clear at close", line_bad, 1'b0);

    // R3: low-rate window runs past the high-rate length
    drive(1'b0, 1'b0, 1'b0, LHI);
    check("R3 no close at high length", line_bad, 1'b0);
    drive(1'b0, 1'b0, 1'b1, TLO + 1);
    drive(1'b0, 1'b0, 1'b0, LLO - LHI - TLO - 1);
    check("R3 low-rate window length", line_bad, 1'b1);

    // R1: asynchronous clear mid-window
    drive(1'b1, 1'b0, 1'b1, 5);
    #1 rst_n = 1'b0;
    #0.5 check("R1 async clear", line_bad, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    viol  = 1'b0;
    // R2: one more edge would still be reset; first window starts on third edge
    repeat (2) @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, LHI - (THI + 1));
    drive(1'b1, 1'b0, 1'b1, THI + 1);
    check("R2 first window aligned", line_bad, 1'b1);

    summary();
  end
endmodule